// File: doc/BRIEF.md
# DRAM Address Range Router

This block decides which memory node owns a physical request address. It holds eight programmable DRAM windows. Each window is a pair of 32-bit registers: a base word that carries the window start, the access enables and the interleave mode, and a limit word that carries the window end, the destination node and the interleave select. A request presents a 40-bit address and a flag that says whether it is a read or a write. One clock later the block reports whether a window claimed the address and, if one did, which node (0 to 7) it is routed to.

Windows may be restricted to reads, to writes, or to both. A window can also take part in 2-, 4- or 8-way node interleaving. In that mode some of address bits 14:12 must match the window's select field before the window claims the request. Software programs the sixteen registers through a simple indexed write port. The read port is combinational. Bits with no defined function are held at zero.

Top module: `dram_range_router`

## Requirements
- R1: After reset every one of the sixteen registers reads as zero, `rsp_valid` is low, and every request misses.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register selected by `cfg_addr`. Bits [3:1] of `cfg_addr` pick the window and bit 0 picks the word: 0 is the base word, 1 is the limit word. While `cfg_we` is low, `cfg_rdata` shows the register selected by `cfg_addr` in the same cycle.
- R3: The only bits that store are base bits 0, 1, 10:8 and 31:16, and limit bits 2:0, 10:8 and 31:16. Every other bit ignores writes and reads as zero.
- R4: Base bits 31:16 and limit bits 31:16 are compared with address bits 39:24. The window covers the range from base to limit, and both ends are included.
- R5: Base bit 0 lets reads hit the window and base bit 1 lets writes hit it. `req_wr` is 1 for a write. A request whose kind is not enabled does not hit.
- R6: Base bits 10:8 select the interleave mode. Code 001 compares A12 with select bit 8. Code 011 compares A12 with select bit 8 and A14 with select bit 10. Code 111 compares A14:12 with select bits 10:8. Code 000 compares nothing. All compared bits must be equal for the window to hit.
- R7: The codes 010, 100, 101 and 110 behave exactly like 000.
- R8: When several windows hit, the lowest-numbered one wins and limit bits 2:0 give `rsp_node`. When no window hits, `rsp_hit` is 0 and `rsp_node` is 0.
- R9: `rsp_valid` is high in exactly the cycle after the one where `req_valid` was high. The decision uses the register contents before any write made in the request cycle. When `rsp_valid` is low, `rsp_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index: window in [3:1], 0 = base and 1 = limit in [0] |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 40 | Physical request address |
| req_wr | input | 1 | 1 = write request, 0 = read request |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_hit | output | 1 | A window claimed the request |
| rsp_node | output | 3 | Destination node of the winning window |

## Verification
Directed addresses are placed on each window boundary and one unit outside it. This separates an inclusive comparison from an exclusive one at both ends. Overlapping windows show whether priority goes to the lowest-numbered window, and read-only and write-only windows show whether the access-kind qualifiers are honoured. Each interleave code is tried with addresses that differ only in A14, A13 or A12. A window must follow exactly the bits its code names, so an address that differs only in a bit the code ignores must route the same way. Randomized register rewrites mixed with back-to-back requests check that a write in the request cycle does not affect that request.

// File: rtl/drr_pkg.sv
package drr_pkg;
  localparam int REG_W  = 32;
  localparam int HI_W   = 16;
  localparam int NODE_W = 3;
  localparam int ILV_W  = 3;

  // Base word fields: [31:16] start, [10:8] interleave code, [1] wr en, [0] rd en
  typedef struct packed {
    logic [HI_W-1:0]  hi;
    logic [ILV_W-1:0] code;
    logic             wr_en;
    logic             rd_en;
  } base_t;

  // Limit word fields: [31:16] end, [10:8] interleave select, [2:0] node
  typedef struct packed {
    logic [HI_W-1:0]   hi;
    logic [ILV_W-1:0]  sel;
    logic [NODE_W-1:0] node;
  } limit_t;

  // Which of A[14:12] take part in the interleave compare (bit0 = A12)
  function automatic logic [ILV_W-1:0] ilv_bits(input logic [ILV_W-1:0] code);
    case (code)
      3'b001:  return 3'b001;
      3'b011:  return 3'b101;
      3'b111:  return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic in_window(input logic [HI_W-1:0] a,
                                     input logic [HI_W-1:0] lo,
                                     input logic [HI_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [REG_W-1:0] pack_base(input base_t b);
    return {b.hi, 5'd0, b.code, 6'd0, b.wr_en, b.rd_en};
  endfunction

  function automatic logic [REG_W-1:0] pack_limit(input limit_t l);
    return {l.hi, 5'd0, l.sel, 5'd0, l.node};
  endfunction
endpackage

// File: rtl/drr_regfile.sv
module drr_regfile
  import drr_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  localparam int PAIR_W = $clog2(NUM_PAIRS),
  localparam int IDX_W  = PAIR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_addr,
  input  logic [REG_W-1:0]     cfg_wdata,
  output logic [REG_W-1:0]     cfg_rdata,
  output base_t                base_q  [NUM_PAIRS],
  output limit_t               limit_q [NUM_PAIRS]
);
  logic [PAIR_W-1:0] wr_pair;
  logic              wr_is_limit;

  assign wr_pair     = cfg_addr[IDX_W-1:1];
  assign wr_is_limit = cfg_addr[0];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[p]  <= '0;
        limit_q[p] <= '0;
      end else if (cfg_we && (wr_pair == PAIR_W'(p))) begin
        if (wr_is_limit) begin
          limit_q[p].hi   <= cfg_wdata[31:16];
          limit_q[p].sel  <= cfg_wdata[10:8];
          limit_q[p].node <= cfg_wdata[2:0];
        end else begin
          base_q[p].hi    <= cfg_wdata[31:16];
          base_q[p].code  <= cfg_wdata[10:8];
          base_q[p].wr_en <= cfg_wdata[1];
          base_q[p].rd_en <= cfg_wdata[0];
        end
      end
    end
  end

  always_comb begin
    if (wr_is_limit) cfg_rdata = pack_limit(limit_q[wr_pair]);
    else             cfg_rdata = pack_base(base_q[wr_pair]);
  end

  // R2
  base_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_is_limit) |=> (base_q[$past(wr_pair)].hi == $past(cfg_wdata[31:16])));
  // R2
  limit_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_is_limit) |=> (limit_q[$past(wr_pair)].node == $past(cfg_wdata[2:0])));
endmodule

// File: rtl/drr_pair_match.sv
module drr_pair_match
  import drr_pkg::*;
(
  input  base_t            base_i,
  input  limit_t           limit_i,
  input  logic [HI_W-1:0]  addr_hi_i,
  input  logic [ILV_W-1:0] addr_ilv_i,
  input  logic             is_wr_i,
  output logic             hit_o
);
  logic             kind_ok;
  logic             range_ok;
  logic [ILV_W-1:0] cmp_mask;
  logic             ilv_ok;

  assign kind_ok  = is_wr_i ? base_i.wr_en : base_i.rd_en;
  assign range_ok = in_window(addr_hi_i, base_i.hi, limit_i.hi);
  assign cmp_mask = ilv_bits(base_i.code);
  assign ilv_ok   = ((addr_ilv_i ^ limit_i.sel) & cmp_mask) == '0;
  assign hit_o    = kind_ok && range_ok && ilv_ok;
endmodule

// File: rtl/drr_first_hit.sv
module drr_first_hit #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  hits_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  grant_o
);
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hits_i[k]) begin
        idx_o   = IW'(k);
        grant_o = N'(1) << k;
      end
    end
  end
  assign any_o = |hits_i;
endmodule

// File: rtl/dram_range_router.sv
module dram_range_router
  import drr_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int ADDR_W    = 40,
  localparam int PAIR_W = $clog2(NUM_PAIRS),
  localparam int IDX_W  = PAIR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [NODE_W-1:0] rsp_node
);
  base_t               base_q  [NUM_PAIRS];
  limit_t              limit_q [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] hit_vec;
  logic [NUM_PAIRS-1:0] grant_vec;
  logic                 any_hit;
  logic [PAIR_W-1:0]    win_idx;
  logic [HI_W-1:0]      addr_hi;
  logic [ILV_W-1:0]     addr_ilv;
  logic                 unused_addr_bits;

  assign addr_hi          = req_addr[ADDR_W-1 -: HI_W];
  assign addr_ilv         = req_addr[14:12];
  assign unused_addr_bits = ^{req_addr[ADDR_W-HI_W-1:15], req_addr[11:0]};

  drr_regfile #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .base_q   (base_q),
    .limit_q  (limit_q)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_match
    drr_pair_match u_match (
      .base_i    (base_q[p]),
      .limit_i   (limit_q[p]),
      .addr_hi_i (addr_hi),
      .addr_ilv_i(addr_ilv),
      .is_wr_i   (req_wr),
      .hit_o     (hit_vec[p])
    );
  end

  drr_first_hit #(.N(NUM_PAIRS)) u_pick (
    .hits_i (hit_vec),
    .any_o  (any_hit),
    .idx_o  (win_idx),
    .grant_o(grant_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_node  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_hit;
      rsp_node  <= (req_valid && any_hit) ? limit_q[win_idx].node : '0;
    end
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit));
  // R8
  miss_node_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_node == '0));
  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
  // R8
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> ((grant_vec != '0) && ((hit_vec & (grant_vec - 1'b1)) == '0)));
endmodule

// File: tb/dram_range_router_bench.sv
`timescale 1ns/1ps
module dram_range_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [39:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_node;

  int checks = 0;
  int errors = 0;
  bit timed_out = 0;

  int unsigned mdl [16];
  bit    exp_v = 0, exp_h = 0;
  int    exp_n = 0;
  string exp_tag = "R1";

  always #2 clk = ~clk;

  dram_range_router u_dram_range_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_wr(req_wr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_node(rsp_node)
  );

  function automatic int unsigned keep_bits(int idx, int unsigned d);
    // R3: base keeps 31:16,10:8,1,0; limit keeps 31:16,10:8,2:0
    if (idx % 2 == 0) return d & 32'hFFFF_0703;
    return d & 32'hFFFF_0707;
  endfunction

  function automatic bit ilv_pass(int code, int sel, int a14_12);
    int a12 = a14_12 % 2;
    int a13 = (a14_12 / 2) % 2;
    int a14 = a14_12 / 4;
    case (code)
      1: return a12 == sel % 2;
      3: return (a12 == sel % 2) && (a14 == sel / 4);
      7: return (a12 == sel % 2) && (a13 == (sel / 2) % 2) && (a14 == sel / 4);
      default: return 1;  // R7
    endcase
  endfunction

  task automatic route(input logic [39:0] a, input bit wr, output bit h, output int node);
    int top = int'(a >> 24);
    int mid = int'((a >> 12) % 8);
    h = 0; node = 0;
    for (int i = 0; i < 8; i++) begin
      int unsigned b = mdl[2*i];
      int unsigned l = mdl[2*i+1];
      bit kind = wr ? b[1] : b[0];
      if (!h && kind && top >= int'(b >> 16) && top <= int'(l >> 16) &&
          ilv_pass(int'((b >> 8) % 8), int'((l >> 8) % 8), mid)) begin
        h = 1; node = int'(l % 8);
      end
    end
  endtask

  task automatic fail_line(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic check_rsp();
    checks++;
    if (rsp_valid !== exp_v) fail_line("R9", "rsp_valid", int'(rsp_valid), int'(exp_v));
    if (exp_v) begin
      checks++;
      if (rsp_hit !== exp_h) fail_line(exp_tag, "rsp_hit", int'(rsp_hit), int'(exp_h));
      checks++;
      if (int'(rsp_node) != exp_n) fail_line(exp_tag, "rsp_node", int'(rsp_node), exp_n);
    end else begin
      checks++;
      if (rsp_hit !== 1'b0) fail_line("R9", "rsp_hit idle", int'(rsp_hit), 0);
    end
  endtask

  task automatic step(bit we, int idx, int unsigned wd, bit rv, logic [39:0] a, bit wr, string tag);
    bit h; int n;
    @(negedge clk);
    check_rsp();
    cfg_we = we; cfg_addr = 4'(idx); cfg_wdata = wd;
    req_valid = rv; req_addr = a; req_wr = wr;
    exp_v = rv; exp_tag = tag;
    route(a, wr, h, n);
    exp_h = rv && h; exp_n = (rv && h) ? n : 0;
    if (we) mdl[idx] = keep_bits(idx, wd);
  endtask

  task automatic wr_reg(int idx, int unsigned d);
    step(1, idx, d, 0, '0, 0, "R2");
  endtask

  task automatic req(logic [39:0] a, bit wr, string tag);
    step(0, 0, 0, 1, a, wr, tag);
  endtask

  task automatic rd_check(int idx, string tag);
    step(0, idx, 0, 0, '0, 0, tag);
    #1;
    checks++;
    if (cfg_rdata !== mdl[idx]) fail_line(tag, $sformatf("rdata[%0d]", idx), int'(cfg_rdata), int'(mdl[idx]));
  endtask

  task automatic run_tests();
    for (int i = 0; i < 16; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all registers zero, nothing valid, everything misses
    for (int i = 0; i < 16; i++) rd_check(i, "R1");
    req({16'h0000, 24'h000000}, 0, "R1");
    req({16'hFFFF, 24'hFFFFFF}, 1, "R1");
    // R3: only defined bits store
    wr_reg(0, 32'hFFFF_FFFF); rd_check(0, "R3");
    wr_reg(1, 32'hFFFF_FFFF); rd_check(1, "R3");
    // R2: plain readback
    wr_reg(0, 32'h1234_0502); rd_check(0, "R2");
    wr_reg(1, 32'h00AB_0306); rd_check(1, "R2");
    // Overlapping windows: pair0 0x10..0x1F node2, pair1 0x18..0x30 node5
    wr_reg(1, 32'h001F_0002); wr_reg(0, 32'h0010_0003);
    wr_reg(3, 32'h0030_0005); wr_reg(2, 32'h0018_0003);
    req({16'h0010, 24'h000000}, 0, "R4");
    req({16'h001F, 24'hFFFFFF}, 1, "R4");
    req({16'h000F, 24'hFFFFFF}, 0, "R4");
    req({16'h0018, 24'h000000}, 0, "R8");
    req({16'h0020, 24'h123456}, 1, "R8");
    req({16'h0030, 24'hFFFFFF}, 0, "R4");
    req({16'h0031, 24'h000000}, 0, "R8");
    // R5: read-only pair2 node3, write-only pair3 node4
    wr_reg(5, 32'h0040_0003); wr_reg(4, 32'h0040_0001);
    wr_reg(7, 32'h0050_0004); wr_reg(6, 32'h0050_0002);
    req({16'h0040, 24'h000000}, 0, "R5");
    req({16'h0040, 24'h000000}, 1, "R5");
    req({16'h0050, 24'h000000}, 0, "R5");
    req({16'h0050, 24'h000000}, 1, "R5");
    // R6: pair4 interleaved node6, pair5 fallback node1, both at 0x80
    wr_reg(11, 32'h0080_0001); wr_reg(10, 32'h0080_0003);
    wr_reg(9, 32'h0080_0106);  wr_reg(8, 32'h0080_0103);
    req({16'h0080, 24'h001000}, 0, "R6");
    req({16'h0080, 24'h000000}, 0, "R6");
    wr_reg(9, 32'h0080_0406);  wr_reg(8, 32'h0080_0303);
    req({16'h0080, 24'h004000}, 0, "R6");
    req({16'h0080, 24'h006000}, 0, "R6");
    req({16'h0080, 24'h005000}, 0, "R6");
    wr_reg(9, 32'h0080_0506);  wr_reg(8, 32'h0080_0703);
    req({16'h0080, 24'h005000}, 0, "R6");
    req({16'h0080, 24'h004000}, 0, "R6");
    // R7: reserved codes act as no interleave
    wr_reg(8, 32'h0080_0203);
    req({16'h0080, 24'h000000}, 0, "R7");
    wr_reg(8, 32'h0080_0603);
    req({16'h0080, 24'h002000}, 1, "R7");
    // R9: request in the same cycle as a write sees old contents
    step(1, 8, 32'h0080_0000, 1, {16'h0080, 24'h000000}, 0, "R9");
    req({16'h0080, 24'h000000}, 0, "R9");
    // Randomized mix
    for (int k = 0; k < 3000; k++) begin
      bit we = ($urandom_range(0, 9) < 3);
      int idx = int'($urandom_range(0, 15));
      int unsigned d = $urandom;
      d = (d & 32'h0000_FFFF) | ((32'h0010 + $urandom_range(0, 15)) << 16);
      step(we, idx, d, ($urandom_range(0, 9) < 7),
           {16'h0010 + 16'($urandom_range(0, 15)), 24'($urandom)}, $urandom_range(0, 1), "R8");
    end
    step(0, 0, 0, 0, '0, 0, "R9");
    step(0, 0, 0, 0, '0, 0, "R9");
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule